// File: doc/BRIEF.md
# Video Active-Area Meter

This block watches a stream of sampled RGB pixels (8 bits per channel) along with horizontal and vertical sync levels. It finds where the visible picture sits inside the sampled raster. A pixel counts as picture when any one of its three colour samples exceeds a programmable threshold. The block keeps the leftmost, topmost, rightmost and bottommost such positions. Over a programmable rectangular window it also sums the absolute differences between horizontally neighbouring green samples. A phase-search routine can use that sum as a sharpness score when it steps the sampling phase.

A start strobe clears the accumulators and arms the block. Measurement starts at the next vertical sync rise and runs for a programmed number of frames. Across those frames the boundaries keep their extreme values and the phase sum keeps growing. When the last frame closes, the result outputs are updated and a one-cycle done pulse is raised. The pixel input is a valid/ready stream. The block never applies back-pressure: ready falls only during reset, and every pixel offered with valid is taken in the same cycle.

Top module: `active_area_meter`

## Requirements
- R1: While `rst_n` is low, `px_ready` and `done` are 0 and all result outputs are 0. From the second clock edge after reset is released, `px_ready` stays 1, and a pixel is taken in every cycle where `px_valid` and `px_ready` are both 1.
- R2: A sync rise is a cycle in which the sync input is 1 after being 0 in the previous cycle. The column of a taken pixel is the number of pixels taken since the last `hsync` rise, so the first one is 0. The row is the number of `hsync` rises since the last `vsync` rise. A pixel taken in a cycle with an `hsync` or `vsync` rise is ignored and does not advance the column. Both counters are 11 bits and stop at 2047.
- R3: A measured pixel is a start hit when any of `px_r`, `px_g` or `px_b` is strictly greater than `cfg_thr_lo`. `res_left` is the smallest column and `res_top` the smallest row among start hits.
- R4: A measured pixel is an end hit when any channel is strictly greater than `cfg_thr_hi` if `cfg_enhanced` is 1, or greater than `cfg_thr_lo` if `cfg_enhanced` is 0. `res_right` is the largest column and `res_bottom` the largest row among end hits.
- R5: If a run has no start hit, `res_left` and `res_top` report 2047. If it has no end hit, `res_right` and `res_bottom` report 0.
- R6: For each measured pixel with `cfg_win_y0 <= row <= cfg_win_y1` and `cfg_win_x0 < col <= cfg_win_x1`, `res_phase` gains the absolute difference between its green sample and that of the previous measured pixel. The sum saturates at 2^PHASE_W-1 (PHASE_W = 30 by default).
- R7: A `start` pulse clears all accumulators, latches the frame count N from `cfg_frames` (0 is taken as 1) and arms the block. The frame count starts at the first `vsync` rise after the start cycle. Only pixels taken while a run is active are measured.
- R8: With N greater than 1, the results cover all N frames: minimum positions for left and top, maximum positions for right and bottom, and the phase sum across every frame.
- R9: The N-th `vsync` rise after the run begins updates all results and raises `done` in the cycle that follows that edge, for exactly one cycle. The result outputs change at no other time.
- R10: A `start` during a run abandons the run without a `done` and re-arms. When `start` falls in the same cycle as the closing `vsync` rise, the finished run is still reported, and the new run begins at the next `vsync` rise, not at this one.
- R11: A `vsync` rise while the block is idle or armed gives no `done` and leaves the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clear and arm strobe |
| cfg_enhanced | input | 1 | 1 selects the separate end threshold |
| cfg_thr_lo | input | 8 | Start threshold (also the end threshold when not enhanced) |
| cfg_thr_hi | input | 8 | End threshold in enhanced mode |
| cfg_frames | input | 4 | Frames per run, 0 means 1 |
| cfg_win_x0 | input | 11 | Phase window left column (exclusive) |
| cfg_win_x1 | input | 11 | Phase window right column (inclusive) |
| cfg_win_y0 | input | 11 | Phase window top row (inclusive) |
| cfg_win_y1 | input | 11 | Phase window bottom row (inclusive) |
| px_valid | input | 1 | Pixel stream valid |
| px_ready | output | 1 | Pixel stream ready |
| px_r | input | 8 | Red sample |
| px_g | input | 8 | Green sample |
| px_b | input | 8 | Blue sample |
| hsync | input | 1 | Horizontal sync level, active high |
| vsync | input | 1 | Vertical sync level, active high |
| res_left | output | 11 | Leftmost start-hit column |
| res_top | output | 11 | Topmost start-hit row |
| res_right | output | 11 | Rightmost end-hit column |
| res_bottom | output | 11 | Bottommost end-hit row |
| res_phase | output | 30 | Saturating phase-quality sum |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge: a fresh `start` strobe and the `vsync` rise that closes a run. The bench raises `start` in the very cycle where it raises `vsync` at the end of a run. It expects `done` together with the results of the finished run. It then sends one frame, which must go unmeasured, and the next `vsync` rise must not complete the new run. Only the frame after that one may show up in the following report. A second overlap is a pixel presented in a sync-rise cycle. The bench places a bright pixel on an `hsync` rise in an otherwise dark frame. That pixel must leave no trace in the results and must not shift the columns of the pixels that follow it.

// File: rtl/active_area_meter_pkg.sv
package active_area_meter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } aa_state_t;

  localparam int NUM_CH = 3;

endpackage

// File: rtl/aa_raster_pos.sv
module aa_raster_pos #(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               px_take,
  input  logic               hsync,
  input  logic               vsync,
  output logic               meas,
  output logic               vs_rise,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row
);
  localparam logic [COORD_W-1:0] POS_MAX = '1;

  logic hs_q, vs_q, hs_rise;

  always_comb begin
    hs_rise = hsync & ~hs_q;
    vs_rise = vsync & ~vs_q;
    meas    = px_take & ~hs_rise & ~vs_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      col  <= '0;
      row  <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (vs_rise || hs_rise) begin
        col <= '0;
      end else if (meas && (col != POS_MAX)) begin
        col <= col + 1'b1;
      end
      if (vs_rise) begin
        row <= '0;
      end else if (hs_rise && (row != POS_MAX)) begin
        row <= row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aa_edge_acc.sv
module aa_edge_acc
  import active_area_meter_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int COORD_W = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         meas_en,
  input  logic [NUM_CH-1:0][CH_W-1:0]  chan,
  input  logic [COORD_W-1:0]           col,
  input  logic [COORD_W-1:0]           row,
  input  logic [CH_W-1:0]              thr_lo,
  input  logic [CH_W-1:0]              thr_hi,
  input  logic                         enhanced,
  output logic [COORD_W-1:0]           left,
  output logic [COORD_W-1:0]           top,
  output logic [COORD_W-1:0]           right,
  output logic [COORD_W-1:0]           bottom
);
  localparam logic [COORD_W-1:0] POS_MAX = '1;

  logic [CH_W-1:0]   end_thr;
  logic [NUM_CH-1:0] over_lo, over_end;
  logic              start_hit, end_hit;

  assign end_thr = enhanced ? thr_hi : thr_lo;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    assign over_lo[i]  = chan[i] > thr_lo;
    assign over_end[i] = chan[i] > end_thr;
  end

  assign start_hit = meas_en & (|over_lo);
  assign end_hit   = meas_en & (|over_end);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      left   <= POS_MAX;
      top    <= POS_MAX;
      right  <= '0;
      bottom <= '0;
    end else begin
      if (start_hit) begin
        if (col < left) left <= col;
        if (row < top)  top  <= row;
      end
      if (end_hit) begin
        if (col > right)  right  <= col;
        if (row > bottom) bottom <= row;
      end
    end
  end
endmodule

// File: rtl/aa_phase_acc.sv
module aa_phase_acc #(
  parameter int CH_W    = 8,
  parameter int COORD_W = 11,
  parameter int PHASE_W = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               meas_en,
  input  logic [CH_W-1:0]    green,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] win_x0,
  input  logic [COORD_W-1:0] win_x1,
  input  logic [COORD_W-1:0] win_y0,
  input  logic [COORD_W-1:0] win_y1,
  output logic [PHASE_W-1:0] acc
);
  localparam int SUM_W = PHASE_W + 1;
  localparam logic [SUM_W-1:0] SAT = {1'b0, {PHASE_W{1'b1}}};

  logic [CH_W-1:0]  g_prev, diff;
  logic             in_win;
  logic [SUM_W-1:0] sum;

  always_comb begin
    in_win = (row >= win_y0) && (row <= win_y1) &&
             (col > win_x0) && (col <= win_x1);
    diff   = (green >= g_prev) ? (green - g_prev) : (g_prev - green);
    sum    = {1'b0, acc} + SUM_W'(diff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      g_prev <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (meas_en) begin
      g_prev <= green;
      if (in_win) acc <= (sum > SAT) ? SAT[PHASE_W-1:0] : sum[PHASE_W-1:0];
    end
  end
endmodule

// File: rtl/aa_seq_ctrl.sv
module aa_seq_ctrl
  import active_area_meter_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               vs_rise,
  input  logic [FRAME_W-1:0] cfg_frames,
  output logic               clr,
  output logic               run,
  output logic               finish,
  output aa_state_t          state
);
  logic [FRAME_W-1:0] frames_q, cnt;
  logic [FRAME_W-1:0] frames_eff;

  assign frames_eff = (cfg_frames == '0) ? FRAME_W'(1) : cfg_frames;
  assign clr        = start;
  assign run        = (state == ST_RUN);
  assign finish     = run && vs_rise &&
                      (({1'b0, cnt} + 1'b1) == {1'b0, frames_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frames_q <= FRAME_W'(1);
      cnt      <= '0;
    end else if (start) begin
      state    <= ST_ARM;
      frames_q <= frames_eff;
      cnt      <= '0;
    end else begin
      case (state)
        ST_ARM: if (vs_rise) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: if (vs_rise) begin
          if (finish) state <= ST_IDLE;
          else        cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/active_area_meter.sv
module active_area_meter
  import active_area_meter_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int COORD_W = 11,
  parameter int PHASE_W = 30,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_enhanced,
  input  logic [CH_W-1:0]    cfg_thr_lo,
  input  logic [CH_W-1:0]    cfg_thr_hi,
  input  logic [FRAME_W-1:0] cfg_frames,
  input  logic [COORD_W-1:0] cfg_win_x0,
  input  logic [COORD_W-1:0] cfg_win_x1,
  input  logic [COORD_W-1:0] cfg_win_y0,
  input  logic [COORD_W-1:0] cfg_win_y1,
  input  logic               px_valid,
  output logic               px_ready,
  input  logic [CH_W-1:0]    px_r,
  input  logic [CH_W-1:0]    px_g,
  input  logic [CH_W-1:0]    px_b,
  input  logic               hsync,
  input  logic               vsync,
  output logic [COORD_W-1:0] res_left,
  output logic [COORD_W-1:0] res_top,
  output logic [COORD_W-1:0] res_right,
  output logic [COORD_W-1:0] res_bottom,
  output logic [PHASE_W-1:0] res_phase,
  output logic               done
);
  logic                        px_take, meas, vs_rise, meas_en;
  logic [COORD_W-1:0]          col, row;
  logic                        clr, run, finish;
  aa_state_t                   seq_state;
  logic [NUM_CH-1:0][CH_W-1:0] chan;
  logic [COORD_W-1:0]          acc_left, acc_top, acc_right, acc_bottom;
  logic [PHASE_W-1:0]          phase_acc_w;

  assign px_take = px_valid & px_ready;
  assign chan    = {px_b, px_g, px_r};
  assign meas_en = meas & run;

  aa_raster_pos #(.COORD_W(COORD_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .px_take (px_take),
    .hsync   (hsync),
    .vsync   (vsync),
    .meas    (meas),
    .vs_rise (vs_rise),
    .col     (col),
    .row     (row)
  );

  aa_seq_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vs_rise    (vs_rise),
    .cfg_frames (cfg_frames),
    .clr        (clr),
    .run        (run),
    .finish     (finish),
    .state      (seq_state)
  );

  aa_edge_acc #(.CH_W(CH_W), .COORD_W(COORD_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .meas_en  (meas_en),
    .chan     (chan),
    .col      (col),
    .row      (row),
    .thr_lo   (cfg_thr_lo),
    .thr_hi   (cfg_thr_hi),
    .enhanced (cfg_enhanced),
    .left     (acc_left),
    .top      (acc_top),
    .right    (acc_right),
    .bottom   (acc_bottom)
  );

  aa_phase_acc #(.CH_W(CH_W), .COORD_W(COORD_W), .PHASE_W(PHASE_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .meas_en (meas_en),
    .green   (px_g),
    .col     (col),
    .row     (row),
    .win_x0  (cfg_win_x0),
    .win_x1  (cfg_win_x1),
    .win_y0  (cfg_win_y0),
    .win_y1  (cfg_win_y1),
    .acc     (phase_acc_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_ready   <= 1'b0;
      done       <= 1'b0;
      res_left   <= '0;
      res_top    <= '0;
      res_right  <= '0;
      res_bottom <= '0;
      res_phase  <= '0;
    end else begin
      px_ready <= 1'b1;
      done     <= finish;
      if (finish) begin
        res_left   <= acc_left;
        res_top    <= acc_top;
        res_right  <= acc_right;
        res_bottom <= acc_bottom;
        res_phase  <= phase_acc_w;
      end
    end
  end
endmodule

// File: rtl/active_area_meter_chk.sv
module active_area_meter_chk
  import active_area_meter_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int PHASE_W = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic               px_ready,
  input aa_state_t          state,
  input logic [PHASE_W-1:0] phase_acc,
  input logic [COORD_W-1:0] res_left,
  input logic [COORD_W-1:0] res_top,
  input logic [COORD_W-1:0] res_right,
  input logic [COORD_W-1:0] res_bottom,
  input logic [PHASE_W-1:0] res_phase
);
  // R1: ready stays high once reset has been released for a cycle
  a_r1_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> px_ready);

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: results move only together with done
  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_left) && $stable(res_top) && $stable(res_right) &&
               $stable(res_bottom) && $stable(res_phase)));

  // R11: done only comes from an active run
  a_r11_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == ST_RUN));

  // R7: a start strobe always leaves the block armed
  a_r7_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_ARM));

  // R6: the phase sum never wraps; it only drops on a clear
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> (phase_acc >= $past(phase_acc)));
endmodule

bind active_area_meter active_area_meter_chk #(
  .COORD_W (COORD_W),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .px_ready   (px_ready),
  .state      (seq_state),
  .phase_acc  (phase_acc_w),
  .res_left   (res_left),
  .res_top    (res_top),
  .res_right  (res_right),
  .res_bottom (res_bottom),
  .res_phase  (res_phase)
);

// File: tb/active_area_meter_bench.sv
`timescale 1ns/1ps
module active_area_meter_bench;
  localparam int W = 24;
  localparam int H = 10;
  localparam int SAT30 = 32'h3FFF_FFFF;
  localparam int SAT10 = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_enhanced = 1'b0;
  logic [7:0]  cfg_thr_lo = 8'd60;
  logic [7:0]  cfg_thr_hi = 8'd110;
  logic [3:0]  cfg_frames = 4'd1;
  logic [10:0] cfg_win_x0 = 11'd0;
  logic [10:0] cfg_win_x1 = 11'd23;
  logic [10:0] cfg_win_y0 = 11'd0;
  logic [10:0] cfg_win_y1 = 11'd2047;
  logic        px_valid = 1'b0;
  logic [7:0]  px_r = 8'd0, px_g = 8'd0, px_b = 8'd0;
  logic        hsync = 1'b0, vsync = 1'b0;
  logic        px_ready, done, px_ready_s, done_s;
  logic [10:0] res_left, res_top, res_right, res_bottom;
  logic [10:0] s_left, s_top, s_right, s_bottom;
  logic [29:0] res_phase;
  logic [9:0]  res_phase_s;

  always #2 clk = ~clk;

  active_area_meter u_active_area_meter (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_enhanced(cfg_enhanced),
    .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi), .cfg_frames(cfg_frames),
    .cfg_win_x0(cfg_win_x0), .cfg_win_x1(cfg_win_x1),
    .cfg_win_y0(cfg_win_y0), .cfg_win_y1(cfg_win_y1),
    .px_valid(px_valid), .px_ready(px_ready), .px_r(px_r), .px_g(px_g), .px_b(px_b),
    .hsync(hsync), .vsync(vsync), .res_left(res_left), .res_top(res_top),
    .res_right(res_right), .res_bottom(res_bottom), .res_phase(res_phase), .done(done)
  );

  active_area_meter #(.PHASE_W(10)) u_small (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_enhanced(cfg_enhanced),
    .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi), .cfg_frames(cfg_frames),
    .cfg_win_x0(cfg_win_x0), .cfg_win_x1(cfg_win_x1),
    .cfg_win_y0(cfg_win_y0), .cfg_win_y1(cfg_win_y1),
    .px_valid(px_valid), .px_ready(px_ready_s), .px_r(px_r), .px_g(px_g), .px_b(px_b),
    .hsync(hsync), .vsync(vsync), .res_left(s_left), .res_top(s_top),
    .res_right(s_right), .res_bottom(s_bottom), .res_phase(res_phase_s), .done(done_s)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int m_state = 0;  // 0 idle, 1 armed, 2 running
  int m_cnt = 0, m_n = 1;
  int e_left = 2047, e_top = 2047, e_right = 0, e_bot = 0;
  int e_ph = 0, e_ph10 = 0;
  int gprev = 0, cur_col = 0, cur_row = 0;
  int seed_init;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int sat_add(input int a, input int d, input int lim);
    longint s;
    s = longint'(a) + longint'(d);
    return (s > longint'(lim)) ? lim : int'(s);
  endfunction

  task automatic model_clear();
    e_left = 2047; e_top = 2047; e_right = 0; e_bot = 0;
    e_ph = 0; e_ph10 = 0;
  endtask

  task automatic model_px(input int rr, input int gg, input int bb);
    int lo, et;
    lo = int'(cfg_thr_lo);
    et = cfg_enhanced ? int'(cfg_thr_hi) : lo;
    if (m_state == 2) begin
      if (rr > lo || gg > lo || bb > lo) begin
        if (cur_col < e_left) e_left = cur_col;
        if (cur_row < e_top)  e_top  = cur_row;
      end
      if (rr > et || gg > et || bb > et) begin
        if (cur_col > e_right) e_right = cur_col;
        if (cur_row > e_bot)   e_bot   = cur_row;
      end
      if (cur_row >= int'(cfg_win_y0) && cur_row <= int'(cfg_win_y1) &&
          cur_col > int'(cfg_win_x0) && cur_col <= int'(cfg_win_x1)) begin
        e_ph   = sat_add(e_ph, absd(gg, gprev), SAT30);
        e_ph10 = sat_add(e_ph10, absd(gg, gprev), SAT10);
      end
      gprev = gg;
    end
    cur_col++;
  endtask

  task automatic send_px(input int rr, input int gg, input int bb);
    int gap;
    gap = int'($urandom_range(0, 2));
    repeat (gap) @(negedge clk);
    px_valid = 1'b1; px_r = 8'(rr); px_g = 8'(gg); px_b = 8'(bb);
    @(negedge clk);
    px_valid = 1'b0;
    model_px(rr, gg, bb);
  endtask

  // R2: optionally offers a pixel in the hsync rise cycle; it must be ignored
  task automatic hs_pulse(input bit with_px);
    hsync = 1'b1;
    if (with_px) begin
      px_valid = 1'b1; px_r = 8'd255; px_g = 8'd255; px_b = 8'd255;
    end
    @(negedge clk);
    hsync = 1'b0; px_valid = 1'b0;
    @(negedge clk);
    cur_row++; cur_col = 0;
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model_clear();
    m_state = 1; m_cnt = 0;
    m_n = (cfg_frames == 4'd0) ? 1 : int'(cfg_frames);
  endtask

  task automatic vs_pulse(input bit with_start, input string tag);
    bit fin;
    fin = (m_state == 2) && (m_cnt + 1 == m_n);
    vsync = 1'b1; start = with_start;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done after vsync rise", int'(done), int'(fin));
    chk("R9", "small done after vsync rise", int'(done_s), int'(fin));
    if (fin) begin
      chk(tag, "left",   int'(res_left),   e_left);
      chk(tag, "top",    int'(res_top),    e_top);
      chk(tag, "right",  int'(res_right),  e_right);
      chk(tag, "bottom", int'(res_bottom), e_bot);
      chk("R6", "phase sum", int'(res_phase), e_ph);
      chk("R6", "phase sum 10-bit", int'(res_phase_s), e_ph10);
    end
    if (with_start) begin
      model_clear();
      m_state = 1; m_cnt = 0;
      m_n = (cfg_frames == 4'd0) ? 1 : int'(cfg_frames);
    end else if (fin) begin
      m_state = 0;
    end else if (m_state == 1) begin
      m_state = 2; m_cnt = 0;
    end else if (m_state == 2) begin
      m_cnt++;
    end
    @(negedge clk);
    chk("R9", "done lasts one cycle", int'(done), 0);
    vsync = 1'b0;
    @(negedge clk);
    cur_row = 0; cur_col = 0;
  endtask

  task automatic send_line(input int y, input int ox0, input int ox1, input int oy0, input int oy1,
                           input int ix0, input int ix1, input int iy0, input int iy1);
    int lo, hi, k, rr, gg, bb, v;
    lo = int'(cfg_thr_lo); hi = int'(cfg_thr_hi);
    hs_pulse(1'b0);
    for (int x = 0; x < W; x++) begin
      rr = int'($urandom_range(0, lo));
      gg = int'($urandom_range(0, lo));
      bb = int'($urandom_range(0, lo));
      k  = int'($urandom_range(0, 2));
      if (x >= ix0 && x <= ix1 && y >= iy0 && y <= iy1) v = int'($urandom_range(200, 255));
      else if (x >= ox0 && x <= ox1 && y >= oy0 && y <= oy1) v = int'($urandom_range(lo + 1, hi));
      else v = -1;
      if (v >= 0) begin
        if (k == 0) rr = v; else if (k == 1) gg = v; else bb = v;
      end
      send_px(rr, gg, bb);
    end
  endtask

  task automatic send_frame(input int ox0, input int ox1, input int oy0, input int oy1,
                            input int ix0, input int ix1, input int iy0, input int iy1);
    for (int y = 1; y <= H; y++) send_line(y, ox0, ox1, oy0, oy1, ix0, ix1, iy0, iy1);
  endtask

  task automatic rand_rect_frame();
    int x0, x1, y0, y1;
    x0 = int'($urandom_range(0, W - 2)); x1 = int'($urandom_range(x0, W - 1));
    y0 = int'($urandom_range(1, H - 1)); y1 = int'($urandom_range(y0, H));
    send_frame(x0, x1, y0, y1, x0, x1, y0, y1);
  endtask

  task automatic rand_cfg();
    int a, b;
    cfg_thr_lo = 8'($urandom_range(40, 100));
    cfg_thr_hi = cfg_thr_lo + 8'd50;
    a = int'($urandom_range(0, W - 1)); b = int'($urandom_range(0, W - 1));
    cfg_win_x0 = 11'((a < b) ? a : b); cfg_win_x1 = 11'((a < b) ? b : a);
    a = int'($urandom_range(0, H)); b = int'($urandom_range(0, H));
    cfg_win_y0 = 11'((a < b) ? a : b); cfg_win_y1 = 11'((a < b) ? b : a);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9: actual run still busy expected finished");
    summary();
    $finish;
  end

  initial begin
    int k_left, k_top, k_right, k_bot, k_ph;
    seed_init = int'($urandom(32'd5150));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(px_ready), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "left in reset", int'(res_left), 0);
    chk("R1", "phase in reset", int'(res_phase), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ready after reset", int'(px_ready), 1);

    // R11: vsync while idle does nothing
    vs_pulse(1'b0, "R11");
    chk("R11", "idle left unchanged", int'(res_left), 0);

    // R3/R4: random single-frame snapshots, both detection modes
    for (int t = 0; t < 6; t++) begin
      rand_cfg();
      cfg_enhanced = 1'($urandom_range(0, 1));
      cfg_frames = 4'($urandom_range(0, 1));
      do_start();
      vs_pulse(1'b0, "R7");
      rand_rect_frame();
      vs_pulse(1'b0, "R3");
    end

    // R8: accumulation over three frames
    for (int t = 0; t < 2; t++) begin
      rand_cfg();
      cfg_enhanced = 1'b0;
      cfg_frames = 4'd3;
      do_start();
      vs_pulse(1'b0, "R7");
      for (int f = 0; f < 3; f++) begin
        rand_rect_frame();
        vs_pulse(1'b0, "R8");
      end
    end

    // R4: enhanced mode, mid-level ring counts only for start edges
    cfg_thr_lo = 8'd60; cfg_thr_hi = 8'd120; cfg_enhanced = 1'b1; cfg_frames = 4'd1;
    do_start();
    vs_pulse(1'b0, "R7");
    send_frame(2, 20, 2, 9, 6, 14, 4, 7);
    vs_pulse(1'b0, "R4");
    chk("R4", "enhanced left", int'(res_left), 2);
    chk("R4", "enhanced top", int'(res_top), 2);
    chk("R4", "enhanced right", int'(res_right), 14);
    chk("R4", "enhanced bottom", int'(res_bottom), 7);

    // R5: empty frame
    cfg_enhanced = 1'b0;
    do_start();
    vs_pulse(1'b0, "R7");
    send_frame(1, 0, 1, 0, 1, 0, 1, 0);
    vs_pulse(1'b0, "R5");
    chk("R5", "empty left", int'(res_left), 2047);
    chk("R5", "empty top", int'(res_top), 2047);
    chk("R5", "empty right", int'(res_right), 0);
    chk("R5", "empty bottom", int'(res_bottom), 0);

    // R6: saturation of the narrow phase sum
    cfg_win_x0 = 11'd0; cfg_win_x1 = 11'd23; cfg_win_y0 = 11'd0; cfg_win_y1 = 11'd2047;
    cfg_frames = 4'd4;
    do_start();
    vs_pulse(1'b0, "R7");
    for (int f = 0; f < 4; f++) begin
      send_frame(0, W - 1, 1, H, 0, W - 1, 1, H);
      vs_pulse(1'b0, "R8");
    end
    chk("R6", "narrow sum saturated", int'(res_phase_s), SAT10);

    // R2: pixel on hsync rise is ignored and does not advance the column
    cfg_frames = 4'd1;
    do_start();
    vs_pulse(1'b0, "R7");
    for (int y = 1; y <= H; y++) begin
      hs_pulse(y == 3);
      for (int x = 0; x < W; x++) begin
        if (y == 3 && x == 5) send_px(250, 10, 10);
        else send_px(int'($urandom_range(0, 60)), int'($urandom_range(0, 60)), 0);
      end
    end
    vs_pulse(1'b0, "R2");
    chk("R2", "single hit column", int'(res_left), 5);
    chk("R2", "single hit row", int'(res_top), 3);
    chk("R2", "single hit right", int'(res_right), 5);

    // R10: start in the same cycle as the closing vsync rise
    rand_cfg();
    cfg_frames = 4'd1;
    do_start();
    vs_pulse(1'b0, "R7");
    rand_rect_frame();
    vs_pulse(1'b1, "R10");
    rand_rect_frame();
    vs_pulse(1'b0, "R10");
    rand_rect_frame();
    vs_pulse(1'b0, "R10");

    // R10: start in the middle of a run abandons it
    cfg_frames = 4'd2;
    do_start();
    vs_pulse(1'b0, "R7");
    for (int y = 1; y <= 4; y++) send_line(y, 0, W - 1, 1, H, 0, W - 1, 1, H);
    do_start();
    for (int y = 5; y <= H; y++) send_line(y, 0, W - 1, 1, H, 0, W - 1, 1, H);
    vs_pulse(1'b0, "R10");
    rand_rect_frame();
    vs_pulse(1'b0, "R10");
    rand_rect_frame();
    vs_pulse(1'b0, "R10");

    // R11: idle vsync rises keep results
    k_left = int'(res_left); k_top = int'(res_top); k_right = int'(res_right);
    k_bot = int'(res_bottom); k_ph = int'(res_phase);
    rand_rect_frame();
    vs_pulse(1'b0, "R11");
    vs_pulse(1'b0, "R11");
    chk("R11", "left kept", int'(res_left), k_left);
    chk("R11", "top kept", int'(res_top), k_top);
    chk("R11", "right kept", int'(res_right), k_right);
    chk("R11", "bottom kept", int'(res_bottom), k_bot);
    chk("R11", "phase kept", int'(res_phase), k_ph);
    chk("R1", "ready held", int'(px_ready), 1);

    summary();
    $finish;
  end
endmodule